// File: doc/BRIEF.md
# Owner-Tagged Cache with Access Checking

A small fully associative cache in which every line records which principal wrote it. Requests come from the currently active principal, which is either the user program or the supervisor. The user issues protected stores and protected loads. The supervisor issues those too, and it also has four privileged maintenance operations:

- pull a word from memory into the cache (prefetch);
- overwrite a cached word;
- discard a line;
- write a line back to memory.

Every read checks the line's owner tag against the requester. None of the supervisor's operations can make another principal's data readable by the supervisor.

Behind the cache is an internal backing array. Each word in it holds a data value, the owner whose key would have sealed it, and the address it was bound to when written. Real ciphers are not modelled. Sealing is represented by the key-owner field, and the integrity hash by the stored binding address.

Any owner or binding mismatch produces a one-cycle fault response. When a request needs a line and none is free, the cache answers busy instead of evicting.

Lines hold several words. Each line has a single owner tag and one valid bit per word. The address is split into a line tag (upper bits) and a word offset (lowest bit with the defaults: 16 words, 2 words per line, 4 lines).

Top module: `owner_tag_cache`

## Requirements
- R1: Protected store (`req_op`=2) writes `req_wdata` into the word at `req_addr` and tags the line with `req_pid`. It uses the line already holding that tag if there is one, otherwise the lowest free line.
- R2: A protected load (`req_op`=1) that hits a valid word returns the word only when the line owner equals `req_pid`. Otherwise it faults with `rsp_data`=0, and this applies when the supervisor (`req_pid`=1) reads user (`req_pid`=0) data.
- R3: A protected load of a word that is not cached checks the memory entry. It faults unless the entry's key owner equals `req_pid` and its bound address equals `req_addr`; an entry never written counts as unbound. If the checks pass, it returns the memory data and caches the word tagged with `req_pid`.
- R4: Prefetch (`req_op`=3, supervisor) caches the memory word tagged with the entry's key owner, not with the supervisor. It faults on a binding mismatch, and it changes nothing when the word is already cached.
- R5: Supervisor overwrite (`req_op`=4) writes `req_wdata` into the word and tags the line with the supervisor.
- R6: A fill or write whose owner differs from the line's current owner leaves only the written word valid. A write by the same owner keeps the line's other words.
- R7: Discard (`req_op`=5, supervisor) clears the line holding the address without writing it back, so a later load sees the older memory contents.
- R8: Write-back (`req_op`=6, supervisor) writes every valid word of the line to memory with key owner = line owner and binding = that word's address, then releases the line. The requester need not own the line.
- R9: Privileged operations (3 to 6) issued with `req_pid`=0 fault and change no state.
- R10: A request that needs a line, finds no line holding its tag and finds no free line answers busy with no state change. For loads and prefetches, the memory checks are made first and a failed check faults rather than answering busy.
- R11: `rsp_valid` follows an accepted request by exactly one cycle, with `rsp_fault`, `rsp_busy` and `rsp_data` valid in that cycle. `rsp_data` is 0 except for a successful load. An idle request (`req_op`=0) answers with no fault. No request means no response.
- R12: Reset empties every line and unbinds every memory entry, and drives all response outputs low.
- R13: No two lines holding any valid word ever carry the same line tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 idle, 1 load, 2 store, 3 prefetch, 4 overwrite, 5 discard, 6 write-back) |
| req_pid | input | 1 | Active principal (0 user, 1 supervisor) |
| req_addr | input | ADDR_W | Word address; line tag in the upper bits, word offset in the low bits |
| req_wdata | input | DATA_W | Store or overwrite data |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Access or binding violation |
| rsp_busy | output | 1 | No line available |
| rsp_data | output | DATA_W | Load result, zero otherwise |

## Verification
Every result of this block (data, fault and busy) is registered once. The response to a request presented before a rising edge is therefore due on the outputs just after that same edge. The bench drives each request on a falling edge and samples the whole response on the next falling edge, half a cycle after it was produced.

Effects on stored state, such as owner tags, discarded words and written-back memory entries, are checked through the response to a later load. That load is issued only after the operation under test has completed. State cleared by reset is checked by a load issued in the first cycle after reset is released.

// File: rtl/ocache_pkg.sv
package ocache_pkg;

   typedef enum logic [2:0] {
      OP_IDLE     = 3'd0,
      OP_SLOAD    = 3'd1,
      OP_SSTORE   = 3'd2,
      OP_PREFETCH = 3'd3,
      OP_WRITE    = 3'd4,
      OP_INVAL    = 3'd5,
      OP_FLUSH    = 3'd6
   } cop_e;

   localparam logic PID_USER = 1'b0;
   localparam logic PID_SUP  = 1'b1;

endpackage

// File: rtl/ocache_lookup.sv
module ocache_lookup #(
   parameter int N     = 4,
   parameter int TAG_W = 3,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]            live,
   input  logic [N-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]        key,
   output logic                    hit,
   output logic [IDX_W-1:0]        hit_idx,
   output logic                    has_free,
   output logic [IDX_W-1:0]        free_idx
);

   logic [N-1:0] match_v;
   logic [N-1:0] free_v;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_cmp
         assign match_v[gi] = live[gi] && (tags[gi] == key);
         assign free_v[gi]  = !live[gi];
      end
   endgenerate

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match_v[i]) hit_idx = IDX_W'(i);
         if (free_v[i])  free_idx = IDX_W'(i);
      end
   end

   assign hit      = |match_v;
   assign has_free = |free_v;

endmodule

// File: rtl/ocache_backing.sv
module ocache_backing #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int WPL    = 2,
   parameter int OFF_W  = 1,
   parameter int TAG_W  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         rd_key,
   output logic                         rd_bound_ok,
   input  logic                         wr_en,
   input  logic [TAG_W-1:0]             wr_tag,
   input  logic [WPL-1:0]               wr_mask,
   input  logic [WPL-1:0][DATA_W-1:0]   wr_data,
   input  logic                         wr_key
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0][DATA_W-1:0] mem_data;
   logic [DEPTH-1:0][ADDR_W-1:0] mem_bind;
   logic [DEPTH-1:0]             mem_key;
   logic [DEPTH-1:0]             mem_bound;
   logic [WPL-1:0][ADDR_W-1:0]   waddr;

   genvar gw;
   generate
      for (gw = 0; gw < WPL; gw++) begin : g_wa
         assign waddr[gw] = (ADDR_W'(wr_tag) << OFF_W) | ADDR_W'(gw);
      end
   endgenerate

   assign rd_data     = mem_data[rd_addr];
   assign rd_key      = mem_key[rd_addr];
   assign rd_bound_ok = mem_bound[rd_addr] && (mem_bind[rd_addr] == rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_data  <= '0;
         mem_bind  <= '0;
         mem_key   <= '0;
         mem_bound <= '0;
      end else if (wr_en) begin
         for (int w = 0; w < WPL; w++) begin
            if (wr_mask[w]) begin
               mem_data[waddr[w]]  <= wr_data[w];
               mem_key[waddr[w]]   <= wr_key;
               mem_bind[waddr[w]]  <= waddr[w];
               mem_bound[waddr[w]] <= 1'b1;
            end
         end
      end
   end

   AST_WB_BINDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mask[0]) |=> (mem_bound[$past(waddr[0])] &&
                                 mem_bind[$past(waddr[0])] == $past(waddr[0]))); // R8

   AST_WB_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mask[0]) |=> (mem_key[$past(waddr[0])] == $past(wr_key))); // R8

endmodule

// File: rtl/owner_tag_cache.sv
module owner_tag_cache
   import ocache_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int WPL       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic              req_pid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic              rsp_busy,
   output logic [DATA_W-1:0] rsp_data
);

   localparam int OFF_W  = (WPL > 1) ? $clog2(WPL) : 0;
   localparam int OFFI_W = (WPL > 1) ? $clog2(WPL) : 1;
   localparam int TAG_W  = ADDR_W - OFF_W;
   localparam int IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   generate
      if ((WPL & (WPL - 1)) != 0) begin : g_bad_wpl
         $error("WPL must be a power of two");
      end
      if (NUM_LINES < 1) begin : g_bad_lines
         $error("NUM_LINES must be at least one");
      end
      if (OFF_W >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W must exceed the word offset width");
      end
   endgenerate

   // line storage
   logic [NUM_LINES-1:0][TAG_W-1:0]           ln_tag;
   logic [NUM_LINES-1:0]                      ln_owner;
   logic [NUM_LINES-1:0][WPL-1:0]             ln_wv;
   logic [NUM_LINES-1:0][WPL-1:0][DATA_W-1:0] ln_data;
   logic [NUM_LINES-1:0]                      ln_live;

   genvar gl;
   generate
      for (gl = 0; gl < NUM_LINES; gl++) begin : g_live
         assign ln_live[gl] = |ln_wv[gl];
      end
   endgenerate

   // address split
   logic [TAG_W-1:0]  cur_tag;
   logic [OFFI_W-1:0] cur_off;
   assign cur_tag = req_addr[ADDR_W-1:OFF_W];
   generate
      if (WPL > 1) begin : g_off
         assign cur_off = req_addr[OFF_W-1:0];
      end else begin : g_nooff
         assign cur_off = '0;
      end
   endgenerate

   // lookup
   logic             m_found, f_found;
   logic [IDX_W-1:0] m_idx, f_idx;

   ocache_lookup #(.N(NUM_LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
      .live     (ln_live),
      .tags     (ln_tag),
      .key      (cur_tag),
      .hit      (m_found),
      .hit_idx  (m_idx),
      .has_free (f_found),
      .free_idx (f_idx)
   );

   logic              m_owner, word_hit, tgt_ok;
   logic [IDX_W-1:0]  tgt_idx;
   logic [DATA_W-1:0] m_word;

   assign m_owner  = ln_owner[m_idx];
   assign word_hit = m_found && ln_wv[m_idx][cur_off];
   assign m_word   = ln_data[m_idx][cur_off];
   assign tgt_ok   = m_found || f_found;
   assign tgt_idx  = m_found ? m_idx : f_idx;

   // backing memory
   logic [DATA_W-1:0] rd_data;
   logic              rd_key, rd_ok;
   logic              flush_wr;

   ocache_backing #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WPL(WPL), .OFF_W(OFF_W), .TAG_W(TAG_W)
   ) u_mem (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_addr     (req_addr),
      .rd_data     (rd_data),
      .rd_key      (rd_key),
      .rd_bound_ok (rd_ok),
      .wr_en       (flush_wr),
      .wr_tag      (cur_tag),
      .wr_mask     (ln_wv[m_idx]),
      .wr_data     (ln_data[m_idx]),
      .wr_key      (m_owner)
   );

   // request decode
   cop_e              op;
   logic              sup;
   logic              nf, nb, fill, fill_own, drop;
   logic [DATA_W-1:0] nd, fill_dat;

   assign op  = cop_e'(req_op);
   assign sup = (req_pid == PID_SUP);

   always_comb begin
      nf       = 1'b0;
      nb       = 1'b0;
      nd       = '0;
      fill     = 1'b0;
      fill_own = req_pid;
      fill_dat = req_wdata;
      drop     = 1'b0;
      flush_wr = 1'b0;
      if (req_valid) begin
         case (op)
            OP_SSTORE: begin
               if (!tgt_ok) nb = 1'b1;
               else fill = 1'b1;
            end
            OP_WRITE: begin
               if (!sup) nf = 1'b1;
               else if (!tgt_ok) nb = 1'b1;
               else begin
                  fill     = 1'b1;
                  fill_own = PID_SUP;
               end
            end
            OP_SLOAD: begin
               if (word_hit) begin
                  if (m_owner == req_pid) nd = m_word;
                  else nf = 1'b1;
               end else if (rd_key != req_pid || !rd_ok) begin
                  nf = 1'b1;
               end else if (!tgt_ok) begin
                  nb = 1'b1;
               end else begin
                  fill     = 1'b1;
                  fill_dat = rd_data;
                  nd       = rd_data;
               end
            end
            OP_PREFETCH: begin
               if (!sup) nf = 1'b1;
               else if (word_hit) begin
                  nf = 1'b0;
               end else if (!rd_ok) begin
                  nf = 1'b1;
               end else if (!tgt_ok) begin
                  nb = 1'b1;
               end else begin
                  fill     = 1'b1;
                  fill_own = rd_key;
                  fill_dat = rd_data;
               end
            end
            OP_INVAL: begin
               if (!sup) nf = 1'b1;
               else drop = m_found;
            end
            OP_FLUSH: begin
               if (!sup) nf = 1'b1;
               else begin
                  drop     = m_found;
                  flush_wr = m_found;
               end
            end
            default: nf = 1'b0;
         endcase
      end
   end

   // state and response registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ln_tag    <= '0;
         ln_owner  <= '0;
         ln_wv     <= '0;
         ln_data   <= '0;
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_busy  <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_fault <= nf;
         rsp_busy  <= nb;
         rsp_data  <= nd;
         if (fill) begin
            ln_tag[tgt_idx]            <= cur_tag;
            ln_owner[tgt_idx]          <= fill_own;
            ln_data[tgt_idx][cur_off]  <= fill_dat;
            if (m_found && m_owner == fill_own)
               ln_wv[tgt_idx][cur_off] <= 1'b1;
            else
               ln_wv[tgt_idx]          <= WPL'(1) << cur_off;
         end
         if (drop) ln_wv[m_idx] <= '0;
      end
   end

   // checks on the response and the line array
   AST_FAULT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault || rsp_busy) |-> rsp_valid); // R11

   AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault || rsp_busy) |-> (rsp_data == '0)); // R11

   AST_BUSY_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_fault && rsp_busy)); // R10

   AST_USER_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_pid == PID_USER && req_op inside {3'd3, 3'd4, 3'd5, 3'd6})
      |=> rsp_fault); // R9

   AST_FOREIGN_READ_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd1 && word_hit && m_owner != req_pid) |=> rsp_fault); // R2

   AST_BUSY_KEEPS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !m_found && !f_found) |=> $stable(ln_wv)); // R10

   genvar ga, gb;
   generate
      for (ga = 0; ga < NUM_LINES; ga++) begin : g_ua
         for (gb = ga + 1; gb < NUM_LINES; gb++) begin : g_ub
            AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
               (ln_live[ga] && ln_live[gb]) |-> (ln_tag[ga] != ln_tag[gb])); // R13
         end
      end
   endgenerate

endmodule

// File: tb/sim_owner_tag_cache.sv
module sim_owner_tag_cache;

   localparam logic [2:0] LD = 3'd1, ST = 3'd2, PF = 3'd3, WR = 3'd4, IV = 3'd5, FL = 3'd6;
   localparam logic U = 1'b0, S = 1'b1;

   typedef struct packed {
      logic [2:0] op;
      logic       pid;
      logic [3:0] addr;
      logic [7:0] wd;
      logic       f;
      logic       b;
      logic [7:0] d;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 47;
   localparam vec_t TBL [NV] = '{
      '{ST, U, 4'd2,  8'h11, 1'b0, 1'b0, 8'h00, 4'd1 },  // R1
      '{LD, U, 4'd2,  8'h00, 1'b0, 1'b0, 8'h11, 4'd2 },  // R2
      '{LD, S, 4'd2,  8'h00, 1'b1, 1'b0, 8'h00, 4'd2 },  // R2 supervisor blocked
      '{ST, U, 4'd3,  8'h22, 1'b0, 1'b0, 8'h00, 4'd1 },  // R1 same line
      '{LD, U, 4'd3,  8'h00, 1'b0, 1'b0, 8'h22, 4'd1 },  // R1
      '{WR, S, 4'd3,  8'h33, 1'b0, 1'b0, 8'h00, 4'd5 },  // R5
      '{LD, S, 4'd3,  8'h00, 1'b0, 1'b0, 8'h33, 4'd5 },  // R5
      '{LD, U, 4'd2,  8'h00, 1'b1, 1'b0, 8'h00, 4'd6 },  // R6 word dropped
      '{FL, S, 4'd2,  8'h00, 1'b0, 1'b0, 8'h00, 4'd8 },  // R8
      '{LD, S, 4'd3,  8'h00, 1'b0, 1'b0, 8'h33, 4'd8 },  // R8 from memory
      '{LD, U, 4'd3,  8'h00, 1'b1, 1'b0, 8'h00, 4'd2 },  // R2
      '{IV, S, 4'd3,  8'h00, 1'b0, 1'b0, 8'h00, 4'd7 },  // R7
      '{ST, U, 4'd8,  8'h44, 1'b0, 1'b0, 8'h00, 4'd1 },  // R1
      '{IV, U, 4'd8,  8'h00, 1'b1, 1'b0, 8'h00, 4'd9 },  // R9
      '{LD, U, 4'd8,  8'h00, 1'b0, 1'b0, 8'h44, 4'd9 },  // R9 line kept
      '{FL, S, 4'd8,  8'h00, 1'b0, 1'b0, 8'h00, 4'd8 },  // R8 foreign owner
      '{PF, S, 4'd8,  8'h00, 1'b0, 1'b0, 8'h00, 4'd4 },  // R4
      '{LD, S, 4'd8,  8'h00, 1'b1, 1'b0, 8'h00, 4'd4 },  // R4 tagged user
      '{LD, U, 4'd8,  8'h00, 1'b0, 1'b0, 8'h44, 4'd4 },  // R4
      '{ST, U, 4'd8,  8'h55, 1'b0, 1'b0, 8'h00, 4'd7 },  // R7
      '{IV, S, 4'd8,  8'h00, 1'b0, 1'b0, 8'h00, 4'd7 },  // R7
      '{LD, U, 4'd8,  8'h00, 1'b0, 1'b0, 8'h44, 4'd7 },  // R7 stale memory
      '{PF, S, 4'd5,  8'h00, 1'b1, 1'b0, 8'h00, 4'd4 },  // R4 unbound
      '{IV, S, 4'd8,  8'h00, 1'b0, 1'b0, 8'h00, 4'd7 },  // R7
      '{LD, S, 4'd8,  8'h00, 1'b1, 1'b0, 8'h00, 4'd3 },  // R3 key owner
      '{LD, U, 4'd8,  8'h00, 1'b0, 1'b0, 8'h44, 4'd3 },  // R3 fill
      '{PF, S, 4'd8,  8'h00, 1'b0, 1'b0, 8'h00, 4'd4 },  // R4 no-op
      '{LD, U, 4'd8,  8'h00, 1'b0, 1'b0, 8'h44, 4'd4 },  // R4
      '{ST, U, 4'd0,  8'h01, 1'b0, 1'b0, 8'h00, 4'd1 },  // R1
      '{ST, U, 4'd2,  8'h02, 1'b0, 1'b0, 8'h00, 4'd1 },  // R1
      '{ST, U, 4'd4,  8'h03, 1'b0, 1'b0, 8'h00, 4'd1 },  // R1 cache full
      '{ST, U, 4'd10, 8'h66, 1'b0, 1'b1, 8'h00, 4'd10},  // R10
      '{LD, U, 4'd10, 8'h00, 1'b1, 1'b0, 8'h00, 4'd10},  // R10 fault first
      '{LD, U, 4'd1,  8'h00, 1'b1, 1'b0, 8'h00, 4'd3 },  // R3 unbound
      '{ST, U, 4'd1,  8'h77, 1'b0, 1'b0, 8'h00, 4'd1 },  // R1 existing line
      '{LD, U, 4'd1,  8'h00, 1'b0, 1'b0, 8'h77, 4'd1 },  // R1
      '{LD, U, 4'd0,  8'h00, 1'b0, 1'b0, 8'h01, 4'd6 },  // R6 same owner keeps
      '{FL, S, 4'd0,  8'h00, 1'b0, 1'b0, 8'h00, 4'd8 },  // R8
      '{ST, U, 4'd10, 8'h66, 1'b0, 1'b0, 8'h00, 4'd10},  // R10 freed line
      '{LD, U, 4'd0,  8'h00, 1'b0, 1'b1, 8'h00, 4'd10},  // R10 busy
      '{LD, U, 4'd10, 8'h00, 1'b0, 1'b0, 8'h66, 4'd10},  // R10
      '{IV, S, 4'd10, 8'h00, 1'b0, 1'b0, 8'h00, 4'd7 },  // R7
      '{LD, U, 4'd0,  8'h00, 1'b0, 1'b0, 8'h01, 4'd8 },  // R8 both words
      '{LD, U, 4'd1,  8'h00, 1'b0, 1'b0, 8'h77, 4'd8 },  // R8
      '{3'd0, U, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd11}, // R11 idle
      '{WR, U, 4'd1,  8'h99, 1'b1, 1'b0, 8'h00, 4'd9 },  // R9
      '{LD, U, 4'd1,  8'h00, 1'b0, 1'b0, 8'h77, 4'd9 }   // R9 unchanged
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_op = '0;
   logic       req_pid = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       rsp_valid, rsp_fault, rsp_busy;
   logic [7:0] rsp_data;
   int         n_chk = 0;
   int         n_bad = 0;

   always #4 clk = ~clk;

   owner_tag_cache u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_pid(req_pid), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_busy(rsp_busy),
      .rsp_data(rsp_data)
   );

   task automatic chk(input string rq, input logic [10:0] act, input logic [10:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {valid,fault,busy,data} actual %b expected %b", rq, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic pid, input logic [3:0] a,
                        input logic [7:0] wd);
      req_valid = 1'b1; req_op = op; req_pid = pid; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R12 reset outputs", {rsp_valid, rsp_fault, rsp_busy, rsp_data}, 11'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 no request", {rsp_valid, rsp_fault, rsp_busy, rsp_data}, 11'b0);
      issue(LD, U, 4'd6, 8'h00);
      chk("R12 empty after reset", {rsp_valid, rsp_fault, rsp_busy, rsp_data}, {3'b110, 8'h00});

      for (int i = 0; i < NV; i++) begin
         issue(TBL[i].op, TBL[i].pid, TBL[i].addr, TBL[i].wd);
         chk($sformatf("R%0d row %0d", TBL[i].rq, i),
             {rsp_valid, rsp_fault, rsp_busy, rsp_data},
             {1'b1, TBL[i].f, TBL[i].b, TBL[i].d});
         @(negedge clk);
         chk($sformatf("R11 gap after row %0d", i), {10'b0, rsp_valid}, 11'b0);
      end

      // reset mid-run clears lines and memory
      rst_n = 1'b0;
      @(negedge clk);
      chk("R12 outputs in reset", {rsp_valid, rsp_fault, rsp_busy, rsp_data}, 11'b0);
      rst_n = 1'b1;
      issue(LD, U, 4'd1, 8'h00);
      chk("R12 memory unbound", {rsp_valid, rsp_fault, rsp_busy, rsp_data}, {3'b110, 8'h00});
      issue(LD, U, 4'd10, 8'h00);
      chk("R12 lines empty", {rsp_valid, rsp_fault, rsp_busy, rsp_data}, {3'b110, 8'h00});

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule